// File: doc/BRIEF.md
# Manchester Line Encoder with End-of-Frame Tail

This block turns a serial NRZ bit stream into a single-level Manchester line signal at half-bit resolution. It is meant for a 10 Mb/s twisted-pair transmit path. It runs on a clock at twice the bit rate, or on any faster clock paced by a half-bit tick. From that tick it derives its own bit clock. The data source presents each bit on the rising edge of that bit clock.

A frame starts on the first cell boundary at which the transmit enable is seen high. Each following cell encodes one data bit for as long as the enable stays high. When the enable is seen low at a boundary, the encoder closes the frame so that the last edge on the line is always low-to-high:

- After a one, the mid-cell rise is the last edge.
- After a zero, the line rises at the cell boundary.

The line is then held high for a fixed number of half-cells. After that the active flag drops and the line returns to its low idle level.

Top module: `manchester_tx`

## Requirements
- R1: While reset is asserted, and right after it, lineOut, lineActive and txBitClk are all 0.
- R2: Each clock with halfTick high toggles txBitClk. A 0-to-1 change of txBitClk marks a cell boundary. txEnable and txData are taken only at boundary ticks; their values at mid-cell ticks have no effect.
- R3: A data bit of 1 is sent as line level 0 for the first half-cell and 1 for the second half-cell.
- R4: A data bit of 0 is sent as line level 1 for the first half-cell and 0 for the second half-cell.
- R5: From idle, a frame starts at the first boundary tick that sees txEnable high. lineActive and the first half-cell level update at that same tick.
- R6: At the first boundary tick that sees txEnable low during a frame, the line is driven to 1 and held at 1 for HOLD_HALVES half-cells (default 2), with lineActive still 1. After a last bit of 1, the line therefore stays high across the boundary. After a last bit of 0, it rises at the boundary.
- R7: At the tick that ends the hold, lineOut and lineActive both go to 0. Outside a frame, lineOut stays 0.
- R8: A txEnable reasserted during the hold does not disturb the hold. With the default hold, a new frame can start at the boundary tick that ends the hold.
- R9: A clock with halfTick low changes none of the outputs.
- R10: When lineActive falls, lineOut was 1 on the preceding clock, so every frame ends on a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| halfTick | input | 1 | Half-bit clock enable; tie high for a double-rate clock |
| txEnable | input | 1 | Frame request, sampled at cell boundaries |
| txData | input | 1 | Serial NRZ data bit, sampled at cell boundaries |
| txBitClk | output | 1 | Derived bit clock; rises at each cell boundary |
| lineOut | output | 1 | Encoded line level |
| lineActive | output | 1 | High while a frame or its closing hold is on the line |

## Verification
A wrong phase register shows up at txBitClk on the very next tick. It also makes a frame start half a cell late, which shows at lineOut within one tick. A data register that keeps a stale bit breaks the second half of the very next cell. A fault in the end-of-frame control shows within HOLD_HALVES+1 ticks as one of three symptoms: a missing rise after a zero, a hold that is too short or too long, or lineActive falling while the line is low. Every frame length up to six bits is swept with every bit pattern, both with a continuous tick and with a gapped one, so any such fault reaches the ports inside one frame.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_HOLD = 2'd2
  } mtxState_t;

  // Strobes issued by the control toward the datapath, one tick at a time
  typedef struct packed {
    logic loadBit;    // capture data, drive first half-cell
    logic secondHalf; // drive second half-cell from captured bit
    logic driveHigh;  // closing rise / hold level
    logic goIdle;     // release the line
  } mtxStrobe_t;

endpackage

// File: rtl/mtx_ctrl.sv
module mtx_ctrl
  import mtx_pkg::*;
#(
  parameter int HOLD_HALVES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       halfTick,
  input  logic       txEnable,
  output logic       bitClk,
  output mtxStrobe_t strobe
);

  localparam int HOLD_W = $clog2(HOLD_HALVES + 1);

  mtxState_t   state, nextState;
  logic [HOLD_W-1:0] holdCnt, nextCnt;
  logic        halfPhase;   // 1 while the second half-cell runs
  logic        atBoundary;

  assign atBoundary = halfPhase;
  assign bitClk     = ~halfPhase;

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextCnt   = holdCnt;
    if (halfTick) begin
      case (state)
        ST_IDLE: begin
          if (atBoundary && txEnable) begin
            strobe.loadBit = 1'b1;
            nextState      = ST_DATA;
          end
        end
        ST_DATA: begin
          if (!atBoundary) begin
            strobe.secondHalf = 1'b1;
          end else if (txEnable) begin
            strobe.loadBit = 1'b1;
          end else begin
            strobe.driveHigh = 1'b1;
            nextState        = ST_HOLD;
            nextCnt          = HOLD_W'(HOLD_HALVES);
          end
        end
        ST_HOLD: begin
          if (holdCnt == HOLD_W'(1)) begin
            if (atBoundary && txEnable) begin
              strobe.loadBit = 1'b1;
              nextState      = ST_DATA;
            end else begin
              strobe.goIdle = 1'b1;
              nextState     = ST_IDLE;
            end
          end else begin
            nextCnt = holdCnt - HOLD_W'(1);
          end
        end
        default: begin
          strobe.goIdle = 1'b1;
          nextState     = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      holdCnt   <= '0;
      halfPhase <= 1'b1;
    end else begin
      state   <= nextState;
      holdCnt <= nextCnt;
      if (halfTick) halfPhase <= ~halfPhase;
    end
  end

endmodule

// File: rtl/mtx_datapath.sv
module mtx_datapath
  import mtx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txData,
  input  mtxStrobe_t strobe,
  output logic       lineOut,
  output logic       lineActive
);

  logic bitReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitReg     <= 1'b0;
      lineOut    <= 1'b0;
      lineActive <= 1'b0;
    end else begin
      if (strobe.loadBit) begin
        bitReg     <= txData;
        lineOut    <= ~txData;
        lineActive <= 1'b1;
      end else if (strobe.secondHalf) begin
        lineOut <= bitReg;
      end else if (strobe.driveHigh) begin
        lineOut    <= 1'b1;
        lineActive <= 1'b1;
      end else if (strobe.goIdle) begin
        lineOut    <= 1'b0;
        lineActive <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/manchester_tx.sv
module manchester_tx
  import mtx_pkg::*;
#(
  parameter int HOLD_HALVES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic halfTick,
  input  logic txEnable,
  input  logic txData,
  output logic txBitClk,
  output logic lineOut,
  output logic lineActive
);

  mtxStrobe_t strobe;

  mtx_ctrl #(.HOLD_HALVES(HOLD_HALVES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .halfTick (halfTick),
    .txEnable (txEnable),
    .bitClk   (txBitClk),
    .strobe   (strobe)
  );

  mtx_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .txData     (txData),
    .strobe     (strobe),
    .lineOut    (lineOut),
    .lineActive (lineActive)
  );

endmodule

// File: rtl/mtx_checker.sv
module mtx_checker (
  input logic clk,
  input logic rstN,
  input logic halfTick,
  input logic txBitClk,
  input logic lineOut,
  input logic lineActive
);

  p_tick_toggles_r2: assert property (@(posedge clk) disable iff (!rstN)
    halfTick |=> (txBitClk != $past(txBitClk)));

  p_start_on_boundary_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineActive) |-> $rose(txBitClk));

  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    !lineActive |-> !lineOut);

  p_no_tick_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    !halfTick |=> ($stable(lineOut) && $stable(lineActive) && $stable(txBitClk)));

  p_end_on_rise_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lineActive) |-> $past(lineOut));

endmodule

bind manchester_tx mtx_checker u_mtxChk (
  .clk        (clk),
  .rstN       (rstN),
  .halfTick   (halfTick),
  .txBitClk   (txBitClk),
  .lineOut    (lineOut),
  .lineActive (lineActive)
);

// File: tb/test_manchester_tx.sv
module test_manchester_tx;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic halfTick = 1'b0;
  logic txEnable = 1'b0;
  logic txData = 1'b0;
  logic txBitClk, lineOut, lineActive;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  manchester_tx #(.HOLD_HALVES(HOLD)) i_manchester_tx (
    .clk(clk), .rstN(rstN), .halfTick(halfTick), .txEnable(txEnable),
    .txData(txData), .txBitClk(txBitClk), .lineOut(lineOut),
    .lineActive(lineActive)
  );

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  // One ticked clock, then `gap` unticked clocks during which nothing may move (R9)
  task automatic halfStep(input int gap);
    logic l, a, b;
    halfTick = 1'b1;
    @(negedge clk);
    halfTick = 1'b0;
    l = lineOut; a = lineActive; b = txBitClk;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check("R9 line", lineOut, l);
      check("R9 active", lineActive, a);
      check("R9 bitclk", txBitClk, b);
    end
  endtask

  task automatic alignBoundary(input int gap);
    txEnable = 1'b0;
    while (txBitClk == 1'b1) begin
      halfStep(gap);
      check("R7 idle line", lineOut, 1'b0);
    end
  endtask

  task automatic sendBits(input logic [7:0] bits, input int len, input int gap);
    for (int i = 0; i < len; i++) begin
      txEnable = 1'b1;
      txData   = bits[i];
      halfStep(gap);
      check(bits[i] ? "R3 first half" : "R4 first half", lineOut, ~bits[i]);
      check("R5 active", lineActive, 1'b1);
      check("R2 boundary", txBitClk, 1'b1);
      txData   = ~bits[i];
      txEnable = (i % 2 == 0);
      halfStep(gap);
      check(bits[i] ? "R3 second half" : "R4 second half", lineOut, bits[i]);
      check("R2 mid", txBitClk, 1'b0);
    end
  endtask

  task automatic runFrame(input logic [7:0] bits, input int len, input int gap);
    alignBoundary(gap);
    sendBits(bits, len, gap);
    txEnable = 1'b0;
    txData   = bits[0];
    for (int h = 0; h < HOLD; h++) begin
      halfStep(gap);
      check("R6 hold line", lineOut, 1'b1);
      check("R6 hold active", lineActive, 1'b1);
    end
    halfStep(gap);
    check("R7 line idle", lineOut, 1'b0);
    check("R7 active idle", lineActive, 1'b0);
  endtask

  initial begin
    repeat (1000 * 200) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 line", lineOut, 1'b0);
    check("R1 active", lineActive, 1'b0);
    check("R1 bitclk", txBitClk, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", lineOut | lineActive | txBitClk, 1'b0);

    // Enable raised before a mid tick must not start a frame (R2, R5)
    halfStep(0);
    txEnable = 1'b1; txData = 1'b1;
    halfStep(0);
    check("R2 mid enable ignored", lineActive, 1'b0);
    halfStep(0);
    check("R5 start at boundary", lineActive, 1'b1);
    check("R3 start level", lineOut, 1'b0);
    txEnable = 1'b0;
    halfStep(0);
    check("R3 mid rise", lineOut, 1'b1);
    halfStep(0);
    halfStep(0);
    halfStep(0);
    check("R7 back to idle", lineActive, 1'b0);

    // Re-enable during hold (R8)
    alignBoundary(0);
    sendBits(8'b1, 1, 0);
    txEnable = 1'b0;
    halfStep(0);
    check("R6 hold entry", lineOut, 1'b1);
    txEnable = 1'b1; txData = 1'b1;
    halfStep(0);
    check("R8 hold kept", lineOut, 1'b1);
    check("R8 hold active", lineActive, 1'b1);
    halfStep(0);
    check("R8 new frame", lineOut, 1'b0);
    check("R8 new frame active", lineActive, 1'b1);
    txEnable = 1'b0;
    halfStep(0);
    check("R8 new frame mid", lineOut, 1'b1);
    halfStep(0); halfStep(0); halfStep(0);
    check("R8 closed", lineActive, 1'b0);

    // Sweep every pattern of length 1..6, continuous and gapped tick
    for (int gap = 0; gap <= 2; gap += 2)
      for (int len = 1; len <= 6; len++)
        for (int pat = 0; pat < (1 << len); pat++)
          runFrame(8'(pat), len, gap);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule